// File: doc/BRIEF.md
# Serial Command Receiver for a Four-Channel PWM Bank

This block receives byte-wide commands from a host over a three-wire serial link and turns them into update strobes for four PWM channels. The host pulls the select line low, pulls the write line low, and clocks in eight data bits, least significant first. When the write line rises, the byte is complete. All serial inputs are asynchronous. They are brought into the system clock domain, and their edges are detected there, so the whole block runs on one clock.

Each command starts with a control byte. It selects a channel, says whether the channel is enabled, and carries the four low data bits. A mode bit in the control byte says whether a data byte with the upper eight bits follows. A disable command ignores the data and mode fields, so no data byte follows it. Every finished command appears for one clock as an update. The update carries the channel, a 12-bit data word, a 12-bit mask that shows which data bits to write, and the enable flag. The PWM bank uses the mask to merge the data into that channel's pending register.

Top module: `serial_cmd_rx`

## Requirements
- R1: After reset, no update is issued and no data byte is pending, so the first complete byte is decoded as a control byte.
- R2: A bit is taken from `sdi` on each rising edge of `sclk` while `cs_n` and `wr_n` are both low. The first bit taken becomes bit 0 of the byte and the eighth becomes bit 7.
- R3: A rising edge of `wr_n` while `cs_n` is low ends a byte. The byte is used only if at least eight bits were taken since the byte started; if more were taken, the last eight form the byte. A byte with fewer bits produces no update.
- R4: Control byte fields: bits 7..4 are data bits 3..0, bit 3 is the enable (1 = on), bits 2..1 are the channel (0..3), and bit 0 is the mode. With enable 1 and mode 0, an update is issued with that channel, data = bits 7..4 in positions 3..0, mask 12'h00F and enable 1.
- R5: With enable 1 and mode 1, no update is issued for the control byte. The next complete byte is the data byte, and it issues one update with data = {data byte, control bits 7..4}, mask 12'hFFF and enable 1.
- R6: With enable 0, an update is issued with data 0, mask 0 and enable 0 for the selected channel. The mode bit is ignored, so the next byte is again a control byte.
- R7: `cs_n` going high drops any partial byte and clears its bit count.
- R8: Rising edges of `sclk` while `wr_n` is high take no bit and do not count toward a byte.
- R9: Each update is high for exactly one clock, and data bits outside the mask are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Asynchronous chip select, active low |
| wr_n | input | 1 | Asynchronous write control, active low; its rising edge ends a byte |
| sclk | input | 1 | Asynchronous serial bit clock |
| sdi | input | 1 | Asynchronous serial data |
| upd_valid | output | 1 | One-clock update strobe |
| upd_chan | output | 2 | Channel being updated |
| upd_data | output | 12 | New data bits |
| upd_mask | output | 12 | Data bits to be written |
| upd_en | output | 1 | New output-enable state |

## Verification
The assertions assume that the host holds each serial line steady for several system clocks:
- Every `sclk` and `wr_n` level is held long enough to pass the synchronisers.
- `sdi` is stable around each `sclk` rise.
- `wr_n` rises only after the last `sclk` rise of a byte, and `cs_n` rises after that.

Under those assumptions, edges are never closer together than two clocks. That spacing is what makes a one-cycle strobe possible. The bench drives every line with phases of four system clocks and never changes two serial lines in the same phase, so it stays inside these assumptions. The odd cases are also built from well-formed edges: short and long bytes, an aborted byte, and `sclk` pulses with `wr_n` high.

// File: rtl/serial_cmd_rx_pkg.sv
package serial_cmd_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int LOW_W  = 4;
  localparam int CH_W   = 2;
  localparam int DATA_W = BYTE_W + LOW_W;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  // bit positions inside the control byte (decoded by the PWM protocol)
  localparam int MODE_BIT = 0;
  localparam int CH_LSB   = 1;
  localparam int EN_BIT   = 3;
  localparam int LOW_LSB  = 4;

  localparam logic [DATA_W-1:0] MASK_LOW  = {{BYTE_W{1'b0}}, {LOW_W{1'b1}}};
  localparam logic [DATA_W-1:0] MASK_FULL = {DATA_W{1'b1}};

  typedef struct packed {
    logic              valid;
    logic [CH_W-1:0]   chan;
    logic [DATA_W-1:0] data;
    logic [DATA_W-1:0] mask;
    logic              en;
  } upd_t;
endpackage

// File: rtl/serial_cmd_rx_sync.sv
module serial_cmd_rx_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= RST_VAL;
      else     stage[s] <= (s == 0) ? d : stage[(s == 0) ? 0 : s - 1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/serial_cmd_rx_shift.sv
module serial_cmd_rx_shift
  import serial_cmd_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              wr_n_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_data
);
  logic              sclk_q, wr_q;
  logic [BYTE_W-1:0] sreg;
  logic [CNT_W-1:0]  cnt;
  logic              sclk_rise, wr_rise, cnt_full;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign wr_rise   = wr_n_s & ~wr_q;
  assign cnt_full  = (cnt == CNT_W'(BYTE_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q    <= 1'b0;
      wr_q      <= 1'b1;
      sreg      <= '0;
      cnt       <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
    end else begin
      sclk_q   <= sclk_s;
      wr_q     <= wr_n_s;
      byte_vld <= 1'b0;
      if (cs_n_s) begin
        cnt <= '0;
      end else if (wr_rise) begin
        byte_vld  <= cnt_full;
        byte_data <= sreg;
        cnt       <= '0;
      end else if (sclk_rise && !wr_n_s) begin
        sreg <= {sdi_s, sreg[BYTE_W-1:1]};
        if (!cnt_full) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_cmd_rx_decode.sv
module serial_cmd_rx_decode
  import serial_cmd_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  output upd_t              upd
);
  logic             pend;
  logic [CH_W-1:0]  pend_chan;
  logic [LOW_W-1:0] pend_low;

  logic             b_mode, b_en;
  logic [CH_W-1:0]  b_chan;
  logic [LOW_W-1:0] b_low;

  assign b_mode = byte_data[MODE_BIT];
  assign b_en   = byte_data[EN_BIT];
  assign b_chan = byte_data[CH_LSB +: CH_W];
  assign b_low  = byte_data[LOW_LSB +: LOW_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      pend_chan <= '0;
      pend_low  <= '0;
      upd       <= '0;
    end else begin
      upd.valid <= 1'b0;
      if (byte_vld) begin
        if (pend) begin
          pend      <= 1'b0;
          upd.valid <= 1'b1;
          upd.chan  <= pend_chan;
          upd.data  <= {byte_data, pend_low};
          upd.mask  <= MASK_FULL;
          upd.en    <= 1'b1;
        end else if (!b_en) begin
          upd.valid <= 1'b1;
          upd.chan  <= b_chan;
          upd.data  <= '0;
          upd.mask  <= '0;
          upd.en    <= 1'b0;
        end else if (!b_mode) begin
          upd.valid <= 1'b1;
          upd.chan  <= b_chan;
          upd.data  <= {{BYTE_W{1'b0}}, b_low};
          upd.mask  <= MASK_LOW;
          upd.en    <= 1'b1;
        end else begin
          pend      <= 1'b1;
          pend_chan <= b_chan;
          pend_low  <= b_low;
        end
      end
    end
  end
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import serial_cmd_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              upd_valid,
  output logic [CH_W-1:0]   upd_chan,
  output logic [DATA_W-1:0] upd_data,
  output logic [DATA_W-1:0] upd_mask,
  output logic              upd_en
);
  logic [3:0]        sync_q;
  logic              byte_vld;
  logic [BYTE_W-1:0] byte_data;
  upd_t              upd;

  serial_cmd_rx_sync #(
    .W       (4),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (4'b1100)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, wr_n, sclk, sdi}),
    .q   (sync_q)
  );

  serial_cmd_rx_shift u_shift (
    .clk       (clk),
    .rst       (rst),
    .cs_n_s    (sync_q[3]),
    .wr_n_s    (sync_q[2]),
    .sclk_s    (sync_q[1]),
    .sdi_s     (sync_q[0]),
    .byte_vld  (byte_vld),
    .byte_data (byte_data)
  );

  serial_cmd_rx_decode u_dec (
    .clk       (clk),
    .rst       (rst),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .upd       (upd)
  );

  assign upd_valid = upd.valid;
  assign upd_chan  = upd.chan;
  assign upd_data  = upd.data;
  assign upd_mask  = upd.mask;
  assign upd_en    = upd.en;
endmodule

// File: rtl/serial_cmd_rx_chk.sv
module serial_cmd_rx_chk (
  input logic        clk,
  input logic        rst,
  input logic        upd_valid,
  input logic [11:0] upd_data,
  input logic [11:0] upd_mask,
  input logic        upd_en
);
  // R1: reset leaves no strobe behind
  a_r1_quiet_after_reset: assert property (@(posedge clk) rst |=> !upd_valid);

  // R9: strobe lasts one clock
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> !upd_valid);

  // R9: no data outside the mask
  a_r9_data_in_mask: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> ((upd_data & ~upd_mask) == 12'h000));

  // R6: a disable writes nothing
  a_r6_disable_no_write: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_en) |-> (upd_mask == 12'h000));

  // R4, R5: an enabled update writes the low nibble or the whole word
  a_r4_enable_mask_shape: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_en) |-> (upd_mask == 12'h00F || upd_mask == 12'hFFF));
endmodule

bind serial_cmd_rx serial_cmd_rx_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .upd_valid (upd_valid),
  .upd_data  (upd_data),
  .upd_mask  (upd_mask),
  .upd_en    (upd_en)
);

// File: tb/tb_serial_cmd_rx.sv
module tb_serial_cmd_rx;
  localparam int PH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, wr_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic        upd_valid, upd_en;
  logic [1:0]  upd_chan;
  logic [11:0] upd_data, upd_mask;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [1:0]  q_chan[$];
  logic [11:0] q_data[$], q_mask[$];
  logic        q_en[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  serial_cmd_rx dut (
    .clk (clk), .rst (rst), .cs_n (cs_n), .wr_n (wr_n), .sclk (sclk), .sdi (sdi),
    .upd_valid (upd_valid), .upd_chan (upd_chan), .upd_data (upd_data),
    .upd_mask (upd_mask), .upd_en (upd_en)
  );

  task automatic wait_ph();
    repeat (PH) @(posedge clk);
  endtask

  function automatic logic [7:0] ctl(logic [3:0] low, logic en, logic [1:0] ch, logic mode);
    return {low, en, ch, mode};
  endfunction

  task automatic expect_upd(logic [1:0] ch, logic [11:0] d, logic [11:0] m, logic en, string tag);
    q_chan.push_back(ch); q_data.push_back(d); q_mask.push_back(m);
    q_en.push_back(en); q_tag.push_back(tag);
  endtask

  task automatic pulse_bit(logic b);
    sdi = b; wait_ph();
    sclk = 1'b1; wait_ph();
    sclk = 1'b0; wait_ph();
  endtask

  // frame of n bits, LSB first
  task automatic send_bits(logic [15:0] v, int n);
    cs_n = 1'b0; wait_ph();
    wr_n = 1'b0; wait_ph();
    for (int i = 0; i < n; i++) pulse_bit(v[i]);
    wr_n = 1'b1; wait_ph();
    cs_n = 1'b1; wait_ph();
  endtask

  task automatic send_byte(logic [7:0] b);
    send_bits({8'h00, b}, 8);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (6) @(posedge clk);
    rst = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  // monitor / scoreboard
  logic prev_valid = 1'b0;
  always @(negedge clk) begin
    if (!rst && upd_valid) begin
      total++;
      if (prev_valid) begin
        bad++;
        $display("FAIL R9: strobe held two cycles, actual=1 expected=0");
      end
      if (q_chan.size() == 0) begin
        bad++;
        $display("FAIL R3/R7/R8: unexpected update actual ch=%0d data=%h mask=%h en=%0d expected none",
                 upd_chan, upd_data, upd_mask, upd_en);
      end else begin
        logic [1:0]  ech;
        logic [11:0] ed, em;
        logic        een;
        string       tg;
        ech = q_chan.pop_front(); ed = q_data.pop_front(); em = q_mask.pop_front();
        een = q_en.pop_front(); tg = q_tag.pop_front();
        if (upd_chan !== ech || upd_data !== ed || upd_mask !== em || upd_en !== een) begin
          bad++;
          $display("FAIL %s: actual ch=%0d data=%h mask=%h en=%0d expected ch=%0d data=%h mask=%h en=%0d",
                   tg, upd_chan, upd_data, upd_mask, upd_en, ech, ed, em, een);
        end
      end
    end
    prev_valid <= upd_valid & ~rst;
  end

  initial begin
    do_reset();
    // R1: quiet after reset
    @(negedge clk);
    total++;
    if (upd_valid !== 1'b0) begin
      bad++; $display("FAIL R1: upd_valid actual=%b expected=0", upd_valid);
    end

    // R2 R4: control-only write to channel 2
    expect_upd(2'd2, 12'h00A, 12'h00F, 1'b1, "R4");
    send_byte(ctl(4'hA, 1'b1, 2'd2, 1'b0));

    // R5: two-byte write, channel 1 data 4A6
    expect_upd(2'd1, 12'h4A6, 12'hFFF, 1'b1, "R5");
    send_byte(ctl(4'h6, 1'b1, 2'd1, 1'b1));
    send_byte(8'h4A);

    // R6: disable ignores data and mode, next byte is control again
    expect_upd(2'd3, 12'h000, 12'h000, 1'b0, "R6");
    send_byte(ctl(4'hF, 1'b0, 2'd3, 1'b1));
    expect_upd(2'd0, 12'h003, 12'h00F, 1'b1, "R6");
    send_byte(ctl(4'h3, 1'b1, 2'd0, 1'b0));

    // R3: short byte dropped
    send_bits(16'h00FF, 5);
    expect_upd(2'd1, 12'h005, 12'h00F, 1'b1, "R3");
    send_byte(ctl(4'h5, 1'b1, 2'd1, 1'b0));

    // R3: ten bits, the last eight count
    expect_upd(2'd3, 12'h00C, 12'h00F, 1'b1, "R3");
    send_bits({6'd0, ctl(4'hC, 1'b1, 2'd3, 1'b0), 2'b11}, 10);

    // R7: abort mid-byte clears the count
    cs_n = 1'b0; wait_ph(); wr_n = 1'b0; wait_ph();
    for (int i = 0; i < 4; i++) pulse_bit(1'b1);
    cs_n = 1'b1; wait_ph(); cs_n = 1'b0; wait_ph();
    for (int i = 0; i < 4; i++) pulse_bit(1'b0);
    wr_n = 1'b1; wait_ph(); cs_n = 1'b1; wait_ph();
    expect_upd(2'd2, 12'h007, 12'h00F, 1'b1, "R7");
    send_byte(ctl(4'h7, 1'b1, 2'd2, 1'b0));

    // R8: sclk with wr_n high does not count
    cs_n = 1'b0; wait_ph();
    for (int i = 0; i < 8; i++) pulse_bit(1'b1);
    wr_n = 1'b0; wait_ph();
    for (int i = 0; i < 4; i++) pulse_bit(1'b1);
    wr_n = 1'b1; wait_ph(); cs_n = 1'b1; wait_ph();
    expect_upd(2'd0, 12'h009, 12'h00F, 1'b1, "R8");
    send_byte(ctl(4'h9, 1'b1, 2'd0, 1'b0));

    // R5: full-scale word on channel 3
    expect_upd(2'd3, 12'hFFF, 12'hFFF, 1'b1, "R5");
    send_byte(ctl(4'hF, 1'b1, 2'd3, 1'b1));
    send_byte(8'hFF);

    // R1: reset clears pending data-byte state
    send_byte(ctl(4'h1, 1'b1, 2'd1, 1'b1));
    do_reset();
    expect_upd(2'd1, 12'h000, 12'h000, 1'b0, "R1");
    send_byte(ctl(4'h0, 1'b0, 2'd1, 1'b0));

    repeat (20) @(posedge clk);
    total++;
    if (q_chan.size() != 0) begin
      bad++; $display("FAIL R5: missing updates actual=%0d expected=0", q_chan.size());
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R1: watchdog expired actual=running expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule